// File: doc/BRIEF.md
# Host-Port Device Discovery Sequencer

This block is a hardware state machine that searches the channels of a host port for a device carrying a given 32-bit identifier. It masters a simple register-bridge interface that gives access to four host-port registers: control, status, address and data. A start pulse sets it running. It first puts the port into a known configuration and clears any stale timeout flag. It then probes channels 0, 1, 2 and 3 in turn. Each probe is a two-phase register read of the device identifier register, with a bounded idle poll after each phase.

A probe that errors or never goes idle only skips its channel, so a missing or hung device cannot hide a good device on a later channel. The first channel whose identifier equals the expected value ends the search. The block then gives a one-cycle done pulse, with found and the channel number held until the next search completes. If the host port is not fitted (has-port low), the block reports not-found at once and never touches the bus.

Top module: `dds_discovery_seq`

## Requirements
- R1: After reset done, found, channel and bus_req are all 0.
- R2: A start with has_port low gives done=1 with found=0 one cycle later, and no bus request is made.
- R3: A search opens with two writes: the control register (select 0) receives CFG_CTRL, then the status register (select 1) receives bit 8 (read-disable) and bit 0 (timeout acknowledge) set. This clears a pending timeout flag.
- R4: Each probe writes the address register (select 2) with the channel in bits 15:14, the read flag in bit 13 and ID_REG_IDX below. It then polls, writes status 0 to clear read-disable, reads the data register (select 3) to launch the cycle, polls again, writes status with bit 8 set, and reads the data register for the identifier.
- R5: An idle poll reads status. If bit 0 (timeout) is set, it writes the read value back to acknowledge it and fails the probe. Otherwise it reads control. Bit 13 set means busy, and the poll repeats after POLL_GAP cycles. The probe fails after MAX_POLLS busy control reads.
- R6: A failed probe moves the search to the next channel.
- R7: The lowest-numbered channel whose identifier equals the expected ID is reported with found=1, and no channel above it is addressed.
- R8: When no channel matches, done comes with found=0 after channel 3 has been probed.
- R9: done is a single-cycle pulse. found and channel change only with done.
- R10: A start, has_port or exp_id change while a search runs has no effect. The expected ID is taken when the search starts.
- R11: A bus request holds its select, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| has_port | input | 1 | High when the host port is fitted |
| exp_id | input | DATA_W | Identifier to search for |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | A matching channel was found |
| channel | output | CH_W | Matching channel number |
| bus_req | output | 1 | Register-bridge request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | SEL_W | Register select |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Bridge acknowledge, one cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
The device model behind the bridge is set up in several channel patterns. In one, every channel is present and only one matches. In another, two channels match, to show that the lower one wins and that probing stops there. There are cases where no channel matches, where an absent channel raises the timeout flag, and where a channel stays busy forever and must use up exactly the poll limit. The model only returns the true identifier when the full address, enable, launch, disable and fetch order is followed. A wrong order or a lost timeout clear therefore shows up as a missed match. Random trials with near-miss identifiers that differ in a single bit separate a true equality compare from a partial one. A start pulse during a search, with the port input dropped and the expected ID flipped, shows that those inputs are ignored.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // register selects seen by the bridge
    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_ADDR = 2'd2;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd3;

    // field positions decoded by the bridge
    localparam int STAT_TO_BIT     = 0;
    localparam int STAT_RDDIS_BIT  = 8;
    localparam int CTRL_BUSY_BIT   = 13;
    localparam int ADDR_RDFLAG_BIT = 13;
    localparam int ADDR_CH_SHIFT   = 14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG_CTRL,
        ST_CFG_STAT,
        ST_ADDR,
        ST_POLL_STAT,
        ST_POLL_ACK,
        ST_POLL_CTRL,
        ST_POLL_WAIT,
        ST_RDEN,
        ST_LAUNCH,
        ST_RDDIS,
        ST_FETCH
    } step_e;

endpackage

// File: rtl/dds_bus_port.sv
module dds_bus_port #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_we,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_done,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [SEL_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] wdata;
    } port_t;

    port_t q, d;

    always_comb begin
        d = q;
        if (q.req && bus_ack) begin
            d.req = 1'b0;
        end else if (!q.req && cmd_go) begin
            d.req   = 1'b1;
            d.we    = cmd_we;
            d.sel   = cmd_sel;
            d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_done  = q.req & bus_ack;
    assign cmd_rdata = bus_rdata;
    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.sel;
    assign bus_wdata = q.wdata;

endmodule

// File: rtl/dds_gap_timer.sv
module dds_gap_timer #(
    parameter int GAP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int GAP_W = $clog2(GAP + 1);

    logic [GAP_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = GAP_W'(GAP);
        else if (cnt_q != '0)  cnt_d = cnt_q - GAP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == GAP_W'(1));

endmodule

// File: rtl/dds_id_match.sv
module dds_id_match #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              equal
);

    localparam int N_LANE = DATA_W / LANE_W;

    logic [N_LANE-1:0] lane_eq;

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        assign lane_eq[i] = (a[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
    end

    assign equal = &lane_eq;

endmodule

// File: rtl/dds_discovery_seq.sv
module dds_discovery_seq
    import dds_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              N_CH       = 4,
    parameter int              ID_REG_IDX = 0,
    parameter int              POLL_GAP   = 16,
    parameter int              MAX_POLLS  = 100,
    parameter logic [31:0]     CFG_CTRL   = 32'h000F_0109,
    localparam int             CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              has_port,
    input  logic [DATA_W-1:0] exp_id,
    output logic              done,
    output logic              found,
    output logic [CH_W-1:0]   channel,
    output logic              bus_req,
    output logic              bus_we,
    output logic [SEL_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int PCW = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        step_e             step;
        logic              pend;
        logic [CH_W-1:0]   ch;
        logic              phase2;
        logic [PCW-1:0]    polls;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] expect_id;
        logic              done;
        logic              found;
        logic [CH_W-1:0]   chan;
    } seq_t;

    seq_t q, d;

    logic              go, cmd_we, cmd_done;
    logic [SEL_W-1:0]  cmd_sel;
    logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
    logic              tmr_load, tmr_exp;
    logic              id_equal;
    logic              fail;
    logic              bus_step;
    logic [PCW-1:0]    polls_nx;
    logic [DATA_W-1:0] probe_addr;
    logic [DATA_W-1:0] rddis_word;
    logic              busy;

    assign polls_nx   = q.polls + PCW'(1);
    assign probe_addr = DATA_W'(ID_REG_IDX)
                      | (DATA_W'(1) << ADDR_RDFLAG_BIT)
                      | (DATA_W'(q.ch) << ADDR_CH_SHIFT);
    assign rddis_word = DATA_W'(1) << STAT_RDDIS_BIT;
    assign bus_step   = (q.step != ST_IDLE) && (q.step != ST_POLL_WAIT);
    assign busy       = (q.step != ST_IDLE);

    dds_bus_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (go),
        .cmd_we    (cmd_we),
        .cmd_sel   (cmd_sel),
        .cmd_wdata (cmd_wdata),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    dds_gap_timer #(.GAP(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    dds_id_match #(.DATA_W(DATA_W), .LANE_W(8)) u_match (
        .a     (cmd_rdata),
        .b     (q.expect_id),
        .equal (id_equal)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        go        = 1'b0;
        cmd_we    = 1'b0;
        cmd_sel   = SEL_CTRL;
        cmd_wdata = '0;
        tmr_load  = 1'b0;
        fail      = 1'b0;

        case (q.step)
            ST_IDLE: begin
                if (start) begin
                    d.expect_id = exp_id;
                    d.ch        = '0;
                    d.pend      = 1'b0;
                    if (!has_port) begin
                        d.done  = 1'b1;
                        d.found = 1'b0;
                        d.chan  = '0;
                    end else begin
                        d.step  = ST_CFG_CTRL;
                    end
                end
            end
            ST_CFG_CTRL: begin
                cmd_we    = 1'b1;
                cmd_sel   = SEL_CTRL;
                cmd_wdata = DATA_W'(CFG_CTRL);
                if (cmd_done) d.step = ST_CFG_STAT;
            end
            ST_CFG_STAT: begin
                cmd_we    = 1'b1;
                cmd_sel   = SEL_STAT;
                cmd_wdata = rddis_word | (DATA_W'(1) << STAT_TO_BIT);
                if (cmd_done) d.step = ST_ADDR;
            end
            ST_ADDR: begin
                cmd_we    = 1'b1;
                cmd_sel   = SEL_ADDR;
                cmd_wdata = probe_addr;
                if (cmd_done) begin
                    d.step   = ST_POLL_STAT;
                    d.phase2 = 1'b0;
                    d.polls  = '0;
                end
            end
            ST_POLL_STAT: begin
                cmd_sel = SEL_STAT;
                if (cmd_done) begin
                    d.stat = cmd_rdata;
                    d.step = cmd_rdata[STAT_TO_BIT] ? ST_POLL_ACK : ST_POLL_CTRL;
                end
            end
            ST_POLL_ACK: begin
                // writing the read value back acknowledges the timeout flag
                cmd_we    = 1'b1;
                cmd_sel   = SEL_STAT;
                cmd_wdata = q.stat;
                if (cmd_done) fail = 1'b1;
            end
            ST_POLL_CTRL: begin
                cmd_sel = SEL_CTRL;
                if (cmd_done) begin
                    d.polls = polls_nx;
                    if (!cmd_rdata[CTRL_BUSY_BIT])
                        d.step = q.phase2 ? ST_RDDIS : ST_RDEN;
                    else if (polls_nx == PCW'(MAX_POLLS))
                        fail = 1'b1;
                    else
                        d.step = ST_POLL_WAIT;
                end
            end
            ST_POLL_WAIT: begin
                if (!q.pend) begin
                    tmr_load = 1'b1;
                    d.pend   = 1'b1;
                end else if (tmr_exp) begin
                    d.pend = 1'b0;
                    d.step = ST_POLL_STAT;
                end
            end
            ST_RDEN: begin
                cmd_we    = 1'b1;
                cmd_sel   = SEL_STAT;
                cmd_wdata = '0;
                if (cmd_done) d.step = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                cmd_sel = SEL_DATA;
                if (cmd_done) begin
                    d.step   = ST_POLL_STAT;
                    d.phase2 = 1'b1;
                    d.polls  = '0;
                end
            end
            ST_RDDIS: begin
                cmd_we    = 1'b1;
                cmd_sel   = SEL_STAT;
                cmd_wdata = rddis_word;
                if (cmd_done) d.step = ST_FETCH;
            end
            ST_FETCH: begin
                cmd_sel = SEL_DATA;
                if (cmd_done) begin
                    if (id_equal) begin
                        d.done  = 1'b1;
                        d.found = 1'b1;
                        d.chan  = q.ch;
                        d.step  = ST_IDLE;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            default: d.step = ST_IDLE;
        endcase

        // one bridge command per bus step, issued on entry
        if (bus_step && !q.pend) begin
            go     = 1'b1;
            d.pend = 1'b1;
        end
        if (cmd_done) d.pend = 1'b0;

        if (fail) begin
            if (q.ch == CH_W'(N_CH - 1)) begin
                d.done  = 1'b1;
                d.found = 1'b0;
                d.chan  = '0;
                d.step  = ST_IDLE;
            end else begin
                d.ch   = q.ch + CH_W'(1);
                d.step = ST_ADDR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.step <= ST_IDLE;
        end else begin
            q      <= d;
        end
    end

    assign done    = q.done;
    assign found   = q.found;
    assign channel = q.chan;

endmodule

// File: rtl/dds_discovery_chk.sv
module dds_discovery_chk #(
    parameter int DATA_W = 32,
    parameter int CH_W   = 2,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              has_port,
    input logic              done,
    input logic              found,
    input logic [CH_W-1:0]   channel,
    input logic              bus_req,
    input logic              bus_we,
    input logic [SEL_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              busy
);

    a_r2_no_port_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !has_port) |=> (done && !found));

    a_r2_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(found) && $stable(channel)));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    a_r10_no_done_midrun: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !(done && !busy && $past(start) && !$past(bus_ack)
                              && !$past(bus_req)));

endmodule

bind dds_discovery_seq dds_discovery_chk #(
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .SEL_W  (dds_pkg::SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .has_port  (has_port),
    .done      (done),
    .found     (found),
    .channel   (channel),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .busy      (busy)
);

// File: tb/dds_discovery_seq_bench.sv
module dds_discovery_seq_bench;
    import dds_pkg::*;

    localparam int          DW    = 32;
    localparam int          IDX   = 5;
    localparam logic [31:0] CFGV  = 32'h000F_0109;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        has_port = 1'b0;
    logic [31:0] exp_id = '0;
    logic        done, found;
    logic [1:0]  channel;
    logic        bus_req, bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    dds_discovery_seq #(
        .DATA_W(DW), .N_CH(4), .ID_REG_IDX(IDX), .POLL_GAP(3),
        .MAX_POLLS(100), .CFG_CTRL(CFGV)
    ) u_dds_discovery_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .has_port(has_port),
        .exp_id(exp_id), .done(done), .found(found), .channel(channel),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int tests = 0;
    int fails = 0;

    // device model
    bit          present [4];
    logic [31:0] dev_id  [4];
    int          busy_a  [4];
    int          busy_d  [4];
    logic        rd_dis = 1'b1, to_flag = 1'b0;
    logic [1:0]  cur_ch = '0;
    int          busy_left = 0;
    logic [31:0] latched = '0;
    logic [31:0] ctrl_reg = '0;

    // transaction log
    int          txn_cnt = 0, max_ch = -1, ack_cnt = 0, stab_err = 0;
    int          ctrl_reads [4];
    logic        log_we [2];
    logic [1:0]  log_sel [2];
    logic [31:0] log_wd [2];
    logic [31:0] addr_word [4];
    int          wcnt = 0;
    bit          hold_v = 0;
    logic [1:0]  h_sel;
    logic        h_we;
    logic [31:0] h_wd;

    task automatic service();
        if (txn_cnt < 2) begin
            log_we[txn_cnt] = bus_we; log_sel[txn_cnt] = bus_addr; log_wd[txn_cnt] = bus_wdata;
        end
        txn_cnt++;
        case (bus_addr)
            SEL_CTRL: if (bus_we) ctrl_reg = bus_wdata;
                      else begin
                          bus_rdata = (busy_left > 0) ? 32'h0000_2000 : 32'h0;
                          if (busy_left > 0) busy_left--;
                          ctrl_reads[cur_ch]++;
                      end
            SEL_STAT: if (bus_we) begin
                          if (bus_wdata[0]) begin
                              if (to_flag) ack_cnt++;
                              to_flag = 1'b0;
                          end
                          rd_dis = bus_wdata[8];
                      end else bus_rdata = {23'b0, rd_dis, 7'b0, to_flag};
            SEL_ADDR: if (bus_we) begin
                          cur_ch = bus_wdata[15:14];
                          addr_word[cur_ch] = bus_wdata;
                          if (int'(cur_ch) > max_ch) max_ch = int'(cur_ch);
                          latched = 32'h0BAD_0BAD;
                          if (!present[cur_ch]) begin to_flag = 1'b1; busy_left = 0; end
                          else busy_left = busy_a[cur_ch];
                      end
            default:  if (!bus_we) begin
                          if (!rd_dis) begin
                              latched = dev_id[cur_ch];
                              busy_left = busy_d[cur_ch];
                              bus_rdata = 32'hFFFF_FFFF;
                          end else bus_rdata = latched;
                      end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; wcnt = 0; hold_v = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (hold_v && (bus_addr != h_sel || bus_we != h_we || bus_wdata != h_wd))
                stab_err++;
            hold_v = 1; h_sel = bus_addr; h_we = bus_we; h_wd = bus_wdata;
            if (wcnt == 0) begin
                service();
                bus_ack = 1'b1;
                hold_v = 0;
                wcnt = $urandom_range(0, 2);
            end else wcnt--;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        txn_cnt = 0; max_ch = -1; ack_cnt = 0;
        for (int i = 0; i < 4; i++) begin ctrl_reads[i] = 0; addr_word[i] = '0; end
    endtask

    task automatic set_dev(input int ch, input bit p, input logic [31:0] id, input int ba, input int bd);
        present[ch] = p; dev_id[ch] = id; busy_a[ch] = ba; busy_d[ch] = bd;
    endtask

    // expected outcome from the requirements
    function automatic int exp_chan(input logic [31:0] e);
        for (int c = 0; c < 4; c++)
            if (present[c] && busy_a[c] < 100 && busy_d[c] < 100 && dev_id[c] == e) return c;
        return -1;
    endfunction

    task automatic run_search(input logic [31:0] e, input bit hp, input bit poke,
                              output int lat, output int dones, output bit f0, output logic [1:0] c0);
        @(negedge clk); exp_id = e; has_port = hp; start = 1'b1;
        @(negedge clk); start = 1'b0; lat = 1; dones = 0;
        while (!done && lat < 8000) begin
            if (poke && lat == 20) begin start = 1'b1; has_port = 1'b0; exp_id = ~e; end
            else if (poke && lat == 21) begin start = 1'b0; has_port = 1'b1; end
            @(negedge clk); lat++;
        end
        f0 = found; c0 = channel;
        if (done) dones = 1;
        repeat (6) begin @(negedge clk); if (done) dones++; end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int lat, dn, want;
        bit f0;
        logic [1:0] c0;
        logic [31:0] e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) set_dev(i, 1, 32'h1000_0000 + i, 0, 0);
        clear_log();
        repeat (3) @(negedge clk);
        chk(done == 0 && found == 0 && channel == 0 && bus_req == 0, "R1 reset",
            {done, found, channel, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: port absent
        run_search(32'h1000_0000, 0, 0, lat, dn, f0, c0);
        chk(lat == 1, "R2 latency", lat, 1);
        chk(f0 == 0, "R2 found", f0, 0);
        chk(txn_cnt == 0, "R2 no access", txn_cnt, 0);

        // R3/R4: stale timeout flag must be cleared; channel 0 matches
        clear_log(); to_flag = 1'b1;
        run_search(32'h1000_0000, 1, 0, lat, dn, f0, c0);
        chk(log_we[0] && log_sel[0] == SEL_CTRL && log_wd[0] == CFGV, "R3 ctrl write", log_wd[0], CFGV);
        chk(log_we[1] && log_sel[1] == SEL_STAT && log_wd[1] == 32'h101, "R3 stat write", log_wd[1], 32'h101);
        chk(f0 && c0 == 0, "R3 found after clear", {f0, c0}, 3'b100);
        chk(addr_word[0] == (32'h2000 | IDX), "R4 address word", addr_word[0], 32'h2000 | IDX);
        chk(dn == 1, "R9 single pulse", dn, 1);

        // R7: channel 2 only matches
        clear_log();
        run_search(32'h1000_0002, 1, 0, lat, dn, f0, c0);
        chk(f0 && c0 == 2, "R7 found ch2", {f0, c0}, 3'b110);
        chk(max_ch == 2, "R7 stop at match", max_ch, 2);
        chk(addr_word[1] == (32'h6000 | IDX), "R4 ch1 address", addr_word[1], 32'h6000 | IDX);
        chk(found && channel == 2, "R9 held", {found, channel}, 3'b110);

        // R5/R6: absent ch0 raises timeout, ch1 matches
        set_dev(0, 0, 0, 0, 0); set_dev(1, 1, 32'hCAFE_0001, 2, 1);
        clear_log();
        run_search(32'hCAFE_0001, 1, 0, lat, dn, f0, c0);
        chk(f0 && c0 == 1, "R6 skip absent", {f0, c0}, 3'b101);
        chk(ack_cnt == 1, "R5 timeout ack", ack_cnt, 1);

        // R5: hung ch0 uses exactly the poll limit, ch3 matches
        set_dev(0, 1, 32'hCAFE_0001, 200, 0); set_dev(1, 1, 32'h1, 0, 0);
        set_dev(2, 1, 32'h2, 1, 3); set_dev(3, 1, 32'hCAFE_0001, 0, 2);
        clear_log();
        run_search(32'hCAFE_0001, 1, 0, lat, dn, f0, c0);
        chk(ctrl_reads[0] == 100, "R5 poll limit", ctrl_reads[0], 100);
        chk(f0 && c0 == 3, "R6 skip hung", {f0, c0}, 3'b111);

        // R8: nothing matches
        clear_log();
        run_search(32'h7777_7777, 1, 0, lat, dn, f0, c0);
        chk(!f0 && c0 == 0, "R8 not found", {f0, c0}, 0);
        chk(max_ch == 3, "R8 all probed", max_ch, 3);

        // R7: two matches, lower wins
        set_dev(0, 1, 32'h1, 0, 0); set_dev(1, 1, 32'hABCD_1234, 1, 1);
        set_dev(2, 1, 32'h2, 0, 0); set_dev(3, 1, 32'hABCD_1234, 0, 0);
        clear_log();
        run_search(32'hABCD_1234, 1, 0, lat, dn, f0, c0);
        chk(f0 && c0 == 1, "R7 lowest match", {f0, c0}, 3'b101);
        chk(max_ch == 1, "R7 no later probe", max_ch, 1);

        // R10: start/has_port/exp_id disturbed mid-run
        clear_log();
        run_search(32'hABCD_1234, 1, 1, lat, dn, f0, c0);
        chk(f0 && c0 == 1, "R10 ignored start", {f0, c0}, 3'b101);
        chk(dn == 1, "R10 one done", dn, 1);

        // random trials
        for (int t = 0; t < 25; t++) begin
            e = $urandom();
            for (int c = 0; c < 4; c++) begin
                set_dev(c, ($urandom_range(0, 3) != 0),
                        ($urandom_range(0, 2) == 0) ? e : e ^ (32'h1 << $urandom_range(0, 31)),
                        $urandom_range(0, 3),
                        ($urandom_range(0, 15) == 0) ? 150 : $urandom_range(0, 3));
            end
            want = exp_chan(e);
            clear_log();
            run_search(e, 1, 0, lat, dn, f0, c0);
            if (want < 0) chk(!f0 && max_ch == 3, "R8 random", {f0, c0}, 0);
            else chk(f0 && int'(c0) == want && max_ch == want, "R7 random", {f0, c0}, want | 4);
        end

        chk(stab_err == 0, "R11 request stable", stab_err, 0);
        finish_run();
    end

endmodule